// File: doc/BRIEF.md
# Line-Addressable Circulating Shift-Register Memory

This block stores data in a set of independent circulating shift registers, called lines, each `LINE_LEN` bits long. A line address selects one of them. Only the selected line is clocked: it rotates once through all of its positions while the rest of the array holds still. One operation therefore takes a full rotation of one line. Access time grows with line length, and the shifting activity is limited to a single register.

A host gives a line address and an operation code, then pulses a start strobe. The block raises busy and streams the selected line out through a serial output, least significant position first. On a write it takes the new contents from a serial input in the same order. On a read or refresh each outgoing bit is fed back into the line. After exactly `LINE_LEN` shifts the line is back at its starting rotational position, busy drops and done pulses for one cycle. A line can hold whole words or one bit slice of many words. That choice is made by how instances are stacked, not inside the block.

Top module: `lineaddr_mem`

## Requirements
- R1: After reset, busy and done are low and every bit of every line reads as zero.
- R2: A start strobe sampled while busy is low makes busy high from the next cycle for exactly LINE_LEN cycles, after which busy is low and done is high for exactly one cycle.
- R3: Read (opCode 0): in the k-th busy cycle (k counted from 0) serialOut shows bit k of the selected line, and the line's contents are unchanged after the operation.
- R4: Write (opCode 1): the value of serialIn in the k-th busy cycle becomes bit k of the selected line. serialOut still shows the old bit k in that cycle.
- R5: Refresh (opCode 2) streams the line on serialOut exactly as a read does and leaves its contents unchanged.
- R6: Lines other than the selected one never shift and keep their contents through any operation.
- R7: A start strobe while busy is high is ignored. Its address and opCode have no effect, and the running operation neither lengthens nor restarts.
- R8: opCode 3 behaves as a refresh.
- R9: A start strobe in the cycle where done is high is accepted, so operations can follow back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStrobe | input | 1 | Begins an operation when busy is low |
| lineAddr | input | $clog2(NUM_LINES) | Line to operate on, sampled with startStrobe |
| opCode | input | 2 | 0 read, 1 write, 2 refresh, 3 refresh |
| serialIn | input | 1 | Write data, one bit per busy cycle |
| serialOut | output | 1 | Current output bit of the selected line |
| busy | output | 1 | High while the selected line rotates |
| done | output | 1 | One-cycle pulse after the last shift |

## Verification
The bench goes after the length of the rotation. An off-by-one count would leave every line rotated by one position, so the next read returns the data shifted and done arrives a cycle early or late. It checks that a write to one line leaves every other line intact, because a decoder that enables more than one line would corrupt neighbours. Start strobes are fired in the middle of an operation, where a design that re-latches the address would finish on the wrong line. Operations are chained off the done cycle, where a design that needs an idle cycle would drop the next request.

// File: rtl/lam_pkg.sv
package lam_pkg;

  typedef enum logic [1:0] {
    OP_READ    = 2'd0,
    OP_WRITE   = 2'd1,
    OP_REFRESH = 2'd2,
    OP_SPARE   = 2'd3
  } lamOp_e;

  // strobes from the sequencer to the line array
  typedef struct packed {
    logic shiftEn;
    logic writeMode;
  } lamCtrl_t;

endpackage

// File: rtl/lam_ctrl.sv
module lam_ctrl #(
  parameter int NUM_LINES = 8,
  parameter int LINE_LEN  = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         startStrobe,
  input  logic [$clog2(NUM_LINES)-1:0] lineAddr,
  input  logic [1:0]                   opCode,
  output lam_pkg::lamCtrl_t            ctrl,
  output logic [$clog2(NUM_LINES)-1:0] selLine,
  output logic                         busy,
  output logic                         done
);
  import lam_pkg::*;

  localparam int CNT_W = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LINE_LEN - 1);

  logic [CNT_W-1:0] shiftCnt;
  lamOp_e           opReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      shiftCnt <= '0;
      selLine  <= '0;
      opReg    <= OP_READ;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (startStrobe) begin
          busy     <= 1'b1;
          shiftCnt <= '0;
          selLine  <= lineAddr;
          opReg    <= lamOp_e'(opCode);
        end
      end else if (shiftCnt == LAST) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        shiftCnt <= shiftCnt + 1'b1;
      end
    end
  end

  always_comb begin
    ctrl.shiftEn   = busy;
    ctrl.writeMode = busy && (opReg == OP_WRITE);
  end

  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rstN)
    busy && shiftCnt == LAST |=> !busy && done); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R2
  AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy)); // R2
  AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rstN)
    busy && shiftCnt != LAST |=> busy && $stable(selLine)); // R7

endmodule

// File: rtl/lam_datapath.sv
module lam_datapath #(
  parameter int NUM_LINES = 8,
  parameter int LINE_LEN  = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  lam_pkg::lamCtrl_t            ctrl,
  input  logic [$clog2(NUM_LINES)-1:0] selLine,
  input  logic                         serialIn,
  output logic                         serialOut
);
  import lam_pkg::*;

  logic [LINE_LEN-1:0]  lineReg [NUM_LINES];
  logic [NUM_LINES-1:0] shiftVec;

  // address decoder: at most one line gets shift pulses
  always_comb begin
    shiftVec = '0;
    if (ctrl.shiftEn) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (selLine == i[$clog2(NUM_LINES)-1:0]) shiftVec[i] = 1'b1;
      end
    end
  end

  assign serialOut = lineReg[selLine][0];

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    logic feedBit;
    assign feedBit = ctrl.writeMode ? serialIn : lineReg[g][0];

    always_ff @(posedge clk) begin
      if (!rstN) lineReg[g] <= '0;
      else if (shiftVec[g]) lineReg[g] <= {feedBit, lineReg[g][LINE_LEN-1:1]};
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !shiftVec[g] |=> $stable(lineReg[g])); // R6
    AST_RECIRC: assert property (@(posedge clk) disable iff (!rstN)
      shiftVec[g] && !ctrl.writeMode |=> lineReg[g][LINE_LEN-1] == $past(lineReg[g][0])); // R3
  end

  AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(shiftVec)); // R6

endmodule

// File: rtl/lineaddr_mem.sv
module lineaddr_mem #(
  parameter int NUM_LINES = 8,
  parameter int LINE_LEN  = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         startStrobe,
  input  logic [$clog2(NUM_LINES)-1:0] lineAddr,
  input  logic [1:0]                   opCode,
  input  logic                         serialIn,
  output logic                         serialOut,
  output logic                         busy,
  output logic                         done
);
  import lam_pkg::*;

  lamCtrl_t                     ctrl;
  logic [$clog2(NUM_LINES)-1:0] selLine;

  lam_ctrl #(.NUM_LINES(NUM_LINES), .LINE_LEN(LINE_LEN)) i_ctrl (
    .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .lineAddr(lineAddr),
    .opCode(opCode), .ctrl(ctrl), .selLine(selLine), .busy(busy), .done(done)
  );

  lam_datapath #(.NUM_LINES(NUM_LINES), .LINE_LEN(LINE_LEN)) i_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .selLine(selLine),
    .serialIn(serialIn), .serialOut(serialOut)
  );

  AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(serialOut) || $past(startStrobe) || $past(done)); // R6

endmodule

// File: tb/test_lineaddr_mem.sv
module test_lineaddr_mem;
  localparam int NL = 8;
  localparam int LL = 16;
  localparam int AW = $clog2(NL);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startStrobe = 1'b0;
  logic [AW-1:0] lineAddr = '0;
  logic [1:0] opCode = '0;
  logic serialIn = 1'b0;
  logic serialOut, busy, done;

  int nChecks = 0;
  int nFails = 0;
  logic [LL-1:0] mdl [NL];

  always #2.5 clk = ~clk;

  lineaddr_mem #(.NUM_LINES(NL), .LINE_LEN(LL)) i_lineaddr_mem (
    .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .lineAddr(lineAddr),
    .opCode(opCode), .serialIn(serialIn), .serialOut(serialOut),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [LL-1:0] nextLine(input logic [LL-1:0] old, input logic [1:0] op,
                                             input logic [LL-1:0] wdata);
    return (op == 2'd1) ? wdata : old;
  endfunction

  // called at a negedge; returns at the negedge where done should be high
  task automatic runOp(input logic [AW-1:0] a, input logic [1:0] op,
                       input logic [LL-1:0] wdata, input bit poke, input string req);
    logic [LL-1:0] expOut;
    expOut = mdl[a];
    startStrobe = 1'b1; lineAddr = a; opCode = op;
    @(negedge clk);
    startStrobe = 1'b0;
    for (int k = 0; k < LL; k++) begin
      startStrobe = 1'b0;
      chk({req, " busy"}, 32'(busy), 32'd1);
      chk({req, " serialOut"}, 32'(serialOut), 32'(expOut[k]));
      serialIn = wdata[k];
      if (poke && k == 2) begin
        // R7: foreign request mid-operation must be ignored
        startStrobe = 1'b1; lineAddr = a + 1'b1; opCode = 2'd1;
      end
      @(negedge clk);
    end
    startStrobe = 1'b0;
    chk("R2 done", 32'(done), 32'd1);
    chk("R2 busy low", 32'(busy), 32'd0);
    mdl[a] = nextLine(mdl[a], op, wdata);
  endtask

  task automatic readBack(input logic [AW-1:0] a, input string req);
    runOp(a, 2'd0, '0, 1'b0, req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NL; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle", 32'(busy), 32'd0);
    readBack(3'd5, "R1 reset contents");
    @(negedge clk);
    chk("R2 done single cycle", 32'(done), 32'd0);

    // directed: write every line with distinct patterns (R4, R6, R9 via chaining)
    for (int i = 0; i < NL; i++)
      runOp(AW'(i), 2'd1, LL'(16'hA5C3 ^ (i * 16'h1111)), 1'b0, "R4 write");
    for (int i = 0; i < NL; i++) readBack(AW'(i), "R6 R9 readback");
    // refresh and spare opcode keep contents (R5, R8)
    runOp(3'd2, 2'd2, LL'(16'hFFFF), 1'b0, "R5 refresh");
    runOp(3'd2, 2'd3, LL'(16'hFFFF), 1'b0, "R8 spare op");
    readBack(3'd2, "R5 R8 after refresh");
    // R7: mid-operation strobe aimed at neighbour line with write
    runOp(3'd0, 2'd1, LL'(16'h0F0F), 1'b1, "R7 write");
    @(negedge clk);
    chk("R7 no restart", 32'(busy), 32'd0);
    readBack(3'd1, "R7 neighbour untouched");
    readBack(3'd0, "R7 target written");
    // corner patterns
    runOp(3'd7, 2'd1, '1, 1'b0, "R4 all ones");
    readBack(3'd7, "R3 all ones");
    runOp(3'd7, 2'd1, LL'(1), 1'b0, "R4 single bit");
    readBack(3'd7, "R3 single bit");

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [AW-1:0] a;
      logic [1:0] op;
      logic [LL-1:0] d;
      a = AW'($urandom_range(NL - 1));
      op = 2'($urandom_range(3));
      d = LL'($urandom);
      runOp(a, op, d, bit'($urandom_range(1)), "R3 R4 R5 random");
      if ($urandom_range(3) == 0) @(negedge clk);
    end
    for (int i = 0; i < NL; i++) readBack(AW'(i), "R6 final sweep");
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #200000;
    nFails++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule